// File: doc/BRIEF.md
# Synchronized Time-of-Day Counter Bank

This block keeps a set of nanosecond time counters in step: one source counter and a parameterized number of port-local counters. All of them run from the same clock. On every cycle each counter adds a fixed-point increment: an 8-bit whole-nanosecond part above a 32-bit fraction. Each counter keeps its fraction below its 64-bit nanosecond count, so rates that are not a whole number of nanoseconds per cycle are tracked exactly. Because every counter is stepped by the same rate from the same clock, counters that start equal stay equal.

Software changes the counters only in two stages. First it writes the values into shadow registers and an operation code into a command register, through a simple read/write register port. These writes change nothing in the counters. Then a separate strobe, `sync_i`, applies the staged operation to every counter on the same clock edge. The operations are:

- load a new time;
- load a new increment;
- add a signed offset;
- freeze every counter's current value into a per-counter capture register.

The capture register lets the value be read out as a consistent low/high word pair. A one-bit ownership flag lets a single requester claim the command path.

Top module: `tsync_timer_bank`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it goes high, every counter reads zero. Also after reset: the increment is 0x13B13B13B (about 1.2308 ns per cycle), the command register reads 0 and the ownership flag reads 0.
- R2: On every clock edge, each counter adds its 40-bit increment (bits 39:32 whole ns, bits 31:0 fraction) to its count and fraction. A carry out of the fraction adds one to the count.
- R3: Writing an operation code to the command register (address 0, bits 7:0) does not change any counter. The code stays readable until a sync edge.
- R4: A staged operation takes effect on the clock edge where `sync_i` is high, on all counters at once. All counters and all increments are always equal to one another.
- R5: Code 0x01 loads the counter with {word at address 3, word at address 2} and clears its fraction. The loaded value is visible after that edge.
- R6: Code 0x02 loads the increment from {address 5 bits 7:0, address 4}. The upper 24 bits written to address 5 are dropped, and address 5 reads back only bits 7:0. The sync edge itself still steps by the old increment.
- R7: Code 0x04 adds the signed 32-bit word at address 4 to the count, on top of the normal step of that edge. The fraction keeps advancing as usual, and carries propagate into the upper 32 bits of the count.
- R8: Code 0x80 latches each counter's count, as it stood before the sync edge, into that counter's capture register. For counter t (0 = source), the capture register reads at address 8+2t (low word) and 9+2t (high word), and holds until the next capture.
- R9: A sync edge clears the command register to 0, so a second strobe does nothing. A command write on the same edge as a strobe takes priority: the written code is kept and the old code is not run.
- R10: Any other code, including 0x0C, changes no counter on a sync edge and is still cleared.
- R11: The ownership flag is at address 6, bit 0. A read returns the flag's value and then sets it. A write stores `wdata[0]`, so writing 0 releases it.
- R12: `rdata` is combinational. It shows the addressed register in the same cycle that `rd_en` is high. It is 0 when `rd_en` is low and for unused addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared oscillator clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write enable |
| rd_en | input | 1 | Register read enable |
| addr | input | ADDR_W (5) | Register word address |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data, combinational |
| sync_i | input | 1 | Execute the staged command on all counters |
| time_o | output | (NUM_PHY+1)*NS_W (192) | Nanosecond counts, counter t in bits t*NS_W upward |

## Verification
- **Writes:** a register write lands on the edge after it is driven.
- **Operations:** the result of a sync operation appears on `time_o` and on the read port one edge after the strobe is driven.
- **Captures:** a capture holds the count seen at the falling edge just before the strobe edge.
- **Reads:** `rdata` is valid in the same half cycle that `rd_en` is driven.

The bench drives inputs and samples outputs on falling edges. Each task knows how many rising edges it consumes. Expected counts are computed from the increment and the number of edges: for fractional rates, the whole part of edges times increment divided by 2^32. Comparisons against a pre-strobe sample use step plus offset.

// File: rtl/tsync_pkg.sv
package tsync_pkg;

   localparam int unsigned OP_W = 8;

   typedef enum logic [OP_W-1:0] {
      OP_NONE      = 8'h00,
      OP_LOAD_TIME = 8'h01,
      OP_LOAD_INC  = 8'h02,
      OP_ADJUST    = 8'h04,
      OP_CAPTURE   = 8'h80
   } tsync_op_e;

   typedef struct packed {
      logic load_time;
      logic load_inc;
      logic adjust;
      logic capture;
   } tsync_act_t;

   localparam int unsigned RA_CMD     = 0;
   localparam int unsigned RA_TIME_LO = 2;
   localparam int unsigned RA_TIME_HI = 3;
   localparam int unsigned RA_ADJ_LO  = 4;
   localparam int unsigned RA_ADJ_HI  = 5;
   localparam int unsigned RA_OWN     = 6;
   localparam int unsigned RA_CAP     = 8;

endpackage

// File: rtl/tsync_timer.sv
module tsync_timer
   import tsync_pkg::*;
#(
   parameter int unsigned NS_W   = 64,
   parameter int unsigned INT_W  = 8,
   parameter int unsigned FRAC_W = 32,
   parameter int unsigned ADJ_W  = 32,
   parameter logic [INT_W+FRAC_W-1:0] INC_RST = 40'h13B13B13B
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  tsync_act_t              act_i,
   input  logic [NS_W-1:0]         time_ld_i,
   input  logic [INT_W+FRAC_W-1:0] inc_ld_i,
   input  logic [ADJ_W-1:0]        adj_i,
   output logic [NS_W-1:0]         ns_o,
   output logic [NS_W-1:0]         cap_o,
   output logic [INT_W-1:0]        inc_int_o
);
   localparam int unsigned INC_W = INT_W + FRAC_W;

   logic [NS_W-1:0]   ns_q, ns_d, step, adj_ext;
   logic [FRAC_W-1:0] frac_q, frac_d;
   logic [FRAC_W:0]   frac_sum;
   logic [INC_W-1:0]  inc_q;
   logic [NS_W-1:0]   cap_q;

   assign frac_sum = {1'b0, frac_q} + {1'b0, inc_q[FRAC_W-1:0]};
   assign step     = NS_W'(inc_q[INC_W-1:FRAC_W]) + NS_W'(frac_sum[FRAC_W]);
   assign adj_ext  = {{(NS_W-ADJ_W){adj_i[ADJ_W-1]}}, adj_i};

   always_comb begin
      ns_d   = ns_q + step;
      frac_d = frac_sum[FRAC_W-1:0];
      if (act_i.load_time) begin
         ns_d   = time_ld_i;
         frac_d = '0;
      end else if (act_i.adjust) begin
         ns_d = ns_q + step + adj_ext;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ns_q   <= '0;
         frac_q <= '0;
         inc_q  <= INC_RST;
         cap_q  <= '0;
      end else begin
         ns_q   <= ns_d;
         frac_q <= frac_d;
         if (act_i.load_inc) inc_q <= inc_ld_i;
         if (act_i.capture)  cap_q <= ns_q;
      end
   end

   assign ns_o      = ns_q;
   assign cap_o     = cap_q;
   assign inc_int_o = inc_q[INC_W-1:FRAC_W];

endmodule

// File: rtl/tsync_regs.sv
module tsync_regs
   import tsync_pkg::*;
#(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NS_W   = 64,
   parameter int unsigned INT_W  = 8,
   parameter int unsigned NUM_T  = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic                      rd_en,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [DATA_W-1:0]         wdata,
   input  logic                      sync_i,
   input  logic [NUM_T*NS_W-1:0]     cap_i,
   output logic [DATA_W-1:0]         rdata,
   output tsync_act_t                act_o,
   output logic [NS_W-1:0]           sh_time_o,
   output logic [INT_W+DATA_W-1:0]   sh_inc_o,
   output logic [DATA_W-1:0]         sh_adj_o,
   output logic [OP_W-1:0]           cmd_o,
   output logic                      own_o
);
   logic [OP_W-1:0]   cmd_q;
   logic [DATA_W-1:0] t_lo_q, t_hi_q, a_lo_q;
   logic [INT_W-1:0]  a_hi_q;
   logic              own_q;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned r);
      return a == ADDR_W'(r);
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         t_lo_q <= '0;
         t_hi_q <= '0;
         a_lo_q <= '0;
         a_hi_q <= '0;
         own_q  <= 1'b0;
      end else begin
         if (wr_en && hit(addr, RA_CMD))     cmd_q <= wdata[OP_W-1:0];
         else if (sync_i)                    cmd_q <= '0;
         if (wr_en && hit(addr, RA_TIME_LO)) t_lo_q <= wdata;
         if (wr_en && hit(addr, RA_TIME_HI)) t_hi_q <= wdata;
         if (wr_en && hit(addr, RA_ADJ_LO))  a_lo_q <= wdata;
         if (wr_en && hit(addr, RA_ADJ_HI))  a_hi_q <= wdata[INT_W-1:0];
         if (wr_en && hit(addr, RA_OWN))     own_q <= wdata[0];
         else if (rd_en && hit(addr, RA_OWN)) own_q <= 1'b1;
      end
   end

   always_comb begin
      act_o.load_time = sync_i && (cmd_q == OP_LOAD_TIME);
      act_o.load_inc  = sync_i && (cmd_q == OP_LOAD_INC);
      act_o.adjust    = sync_i && (cmd_q == OP_ADJUST);
      act_o.capture   = sync_i && (cmd_q == OP_CAPTURE);
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         if (hit(addr, RA_CMD))     rdata = DATA_W'(cmd_q);
         if (hit(addr, RA_TIME_LO)) rdata = t_lo_q;
         if (hit(addr, RA_TIME_HI)) rdata = t_hi_q;
         if (hit(addr, RA_ADJ_LO))  rdata = a_lo_q;
         if (hit(addr, RA_ADJ_HI))  rdata = DATA_W'(a_hi_q);
         if (hit(addr, RA_OWN))     rdata = DATA_W'(own_q);
         for (int t = 0; t < NUM_T; t++) begin
            if (hit(addr, RA_CAP + 2*t))
               rdata = cap_i[t*NS_W +: DATA_W];
            if (hit(addr, RA_CAP + 2*t + 1))
               rdata = cap_i[t*NS_W + DATA_W +: DATA_W];
         end
      end
   end

   assign sh_time_o = {t_hi_q, t_lo_q};
   assign sh_inc_o  = {a_hi_q, a_lo_q};
   assign sh_adj_o  = a_lo_q;
   assign cmd_o     = cmd_q;
   assign own_o     = own_q;

endmodule

// File: rtl/tsync_timer_bank.sv
module tsync_timer_bank
   import tsync_pkg::*;
#(
   parameter int unsigned NUM_PHY = 2,
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned NS_W    = 64,
   parameter int unsigned INT_W   = 8,
   parameter int unsigned FRAC_W  = 32,
   parameter logic [INT_W+FRAC_W-1:0] INC_RST = 40'h13B13B13B
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic                          rd_en,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [DATA_W-1:0]             wdata,
   output logic [DATA_W-1:0]             rdata,
   input  logic                          sync_i,
   output logic [(NUM_PHY+1)*NS_W-1:0]   time_o
);
   localparam int unsigned NUM_T = NUM_PHY + 1;
   localparam int unsigned INC_W = INT_W + FRAC_W;

   if (NS_W != 2*DATA_W) begin : g_bad_ns
      $error("NS_W must be twice DATA_W");
   end
   if (FRAC_W != DATA_W) begin : g_bad_frac
      $error("FRAC_W must equal DATA_W");
   end
   if (INT_W > DATA_W || INT_W < 1) begin : g_bad_int
      $error("INT_W out of range");
   end
   if (RA_CAP + 2*NUM_T > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for capture registers");
   end

   tsync_act_t              act;
   logic [NS_W-1:0]         sh_time;
   logic [INC_W-1:0]        sh_inc;
   logic [DATA_W-1:0]       sh_adj;
   logic [OP_W-1:0]         cmd_q;
   logic                    own_q;
   logic [NUM_T*NS_W-1:0]   cap_all;
   logic [NUM_T*INT_W-1:0]  inc_int_all;

   tsync_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NS_W(NS_W), .INT_W(INT_W), .NUM_T(NUM_T)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .sync_i(sync_i), .cap_i(cap_all), .rdata(rdata),
      .act_o(act), .sh_time_o(sh_time), .sh_inc_o(sh_inc), .sh_adj_o(sh_adj),
      .cmd_o(cmd_q), .own_o(own_q)
   );

   for (genvar t = 0; t < NUM_T; t++) begin : g_tmr
      tsync_timer #(
         .NS_W(NS_W), .INT_W(INT_W), .FRAC_W(FRAC_W), .ADJ_W(DATA_W), .INC_RST(INC_RST)
      ) u_tmr (
         .clk(clk), .rst_n(rst_n), .act_i(act), .time_ld_i(sh_time),
         .inc_ld_i(sh_inc), .adj_i(sh_adj),
         .ns_o(time_o[t*NS_W +: NS_W]),
         .cap_o(cap_all[t*NS_W +: NS_W]),
         .inc_int_o(inc_int_all[t*INT_W +: INT_W])
      );
   end

endmodule

// File: rtl/tsync_chk.sv
module tsync_chk #(
   parameter int unsigned NUM_T  = 3,
   parameter int unsigned NS_W   = 64,
   parameter int unsigned INT_W  = 8,
   parameter int unsigned ADDR_W = 5
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     wr_en,
   input logic                     rd_en,
   input logic [ADDR_W-1:0]        addr,
   input logic                     sync_i,
   input logic [7:0]               cmd_q,
   input logic                     own_q,
   input logic [NS_W-1:0]          sh_time,
   input logic [NUM_T*NS_W-1:0]    time_all,
   input logic [NUM_T*INT_W-1:0]   inc_int_all
);
   logic [NS_W-1:0]  t0;
   logic [INT_W-1:0] i0;
   logic             cmd_wr;
   assign t0     = time_all[NS_W-1:0];
   assign i0     = inc_int_all[INT_W-1:0];
   assign cmd_wr = wr_en && (addr == ADDR_W'(0));

   // R2: without a strobe, the count moves by the whole increment, plus at most one carry
   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_i |=> ((t0 - $past(t0)) == NS_W'($past(i0)) ||
                   (t0 - $past(t0)) == NS_W'($past(i0)) + NS_W'(1)));

   // R3: the staged code is held until a strobe or a new write
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sync_i && !cmd_wr) |=> $stable(cmd_q));

   // R5: a load-time strobe puts the shadow time on the source counter
   p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_i && cmd_q == 8'h01) |=> t0 == $past(sh_time));

   // R9: the strobe clears the command unless a write lands on the same edge
   p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_i && !cmd_wr) |=> cmd_q == 8'h00);

   // R11: an ownership read with no write sets the flag
   p_own_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !wr_en && addr == ADDR_W'(6)) |=> own_q);

   for (genvar t = 1; t < NUM_T; t++) begin : g_eq
      // R4: every port counter tracks the source counter
      p_equal_r4: assert property (@(posedge clk) disable iff (!rst_n)
         time_all[t*NS_W +: NS_W] == t0);
      // R4: every increment matches the source increment
      p_inc_eq_r4: assert property (@(posedge clk) disable iff (!rst_n)
         inc_int_all[t*INT_W +: INT_W] == i0);
   end

endmodule

bind tsync_timer_bank tsync_chk #(
   .NUM_T(NUM_PHY + 1), .NS_W(NS_W), .INT_W(INT_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
   .sync_i(sync_i), .cmd_q(cmd_q), .own_q(own_q), .sh_time(sh_time),
   .time_all(time_o), .inc_int_all(inc_int_all)
);

// File: tb/sim_tsync_timer_bank.sv
module sim_tsync_timer_bank;
   localparam int CLK_PERIOD = 10;
   localparam int NUM_T = 3;
   localparam logic [63:0] NOM_INC = 64'h13B13B13B;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0, sync_i = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [NUM_T*64-1:0] time_o;

   int n_chk = 0;
   int n_fail = 0;

   tsync_timer_bank u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .sync_i(sync_i), .time_o(time_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [63:0] tm(input int t);
      return time_o[t*64 +: 64];
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = 5'(a); wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = 5'(a);
      #1 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic sync_get(output logic [63:0] pre);
      @(negedge clk);
      pre = tm(0);
      sync_i = 1'b1;
      @(negedge clk);
      sync_i = 1'b0;
   endtask

   task automatic chk_all_equal(input string req);
      for (int t = 1; t < NUM_T; t++) chk(req, tm(t), tm(0));
   endtask

   task automatic t_reset;
      logic [31:0] d;
      repeat (3) @(negedge clk);
      chk("R1 zero in reset", tm(0), 64'd0);
      rst_n = 1'b1;
      chk("R1 zero after release", tm(0), 64'd0);
      repeat (13) @(negedge clk);
      chk("R1 R2 nominal rate", tm(0), (64'd13 * NOM_INC) >> 32);
      chk_all_equal("R4 equal after reset");
      rd(0, d); chk("R1 cmd reset", 64'(d), 64'd0);
      rd(1, d); chk("R12 unused addr", 64'(d), 64'd0);
   endtask

   task automatic t_inc_and_init;
      logic [63:0] v;
      logic [31:0] d;
      wr(5, 32'hABCDEF01);
      wr(4, 32'h0);
      wr(0, 32'h02);
      sync_get(v);
      rd(5, d); chk("R6 upper bits dropped", 64'(d), 64'h01);
      wr(2, 32'd1000);
      wr(3, 32'd0);
      wr(0, 32'h01);
      sync_get(v);
      chk("R5 load time", tm(0), 64'd1000);
      chk_all_equal("R4 load on all");
      repeat (5) @(negedge clk);
      chk("R6 integer rate", tm(0), 64'd1005);
      @(negedge clk);
      addr = 5'd2;
      #1 chk("R12 rd_en low gives 0", 64'(rdata), 64'd0);
   endtask

   task automatic t_stage;
      logic [63:0] a, v;
      logic [31:0] d;
      wr(0, 32'h01);
      a = tm(0);
      repeat (3) @(negedge clk);
      chk("R3 staged no effect", tm(0), a + 64'd3);
      rd(0, d); chk("R3 code held", 64'(d), 64'h01);
      sync_get(v);
      chk("R4 strobe applies", tm(0), 64'd1000);
      rd(0, d); chk("R9 cmd cleared", 64'(d), 64'd0);
      sync_get(v);
      chk("R9 second strobe no-op", tm(0), v + 64'd1);
      @(negedge clk);
      wr_en = 1'b1; addr = 5'd0; wdata = 32'h01; sync_i = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; sync_i = 1'b0;
      rd(0, d); chk("R9 write wins over strobe", 64'(d), 64'h01);
      wr(0, 32'h00);
   endtask

   task automatic t_adjust;
      logic [63:0] v;
      wr(4, 32'hFFFFFFFB);
      wr(0, 32'h04);
      sync_get(v);
      chk("R7 negative adjust", tm(0), v + 64'd1 - 64'd5);
      chk_all_equal("R4 adjust on all");
      wr(2, 32'hFFFFFFF0);
      wr(3, 32'h0);
      wr(0, 32'h01);
      sync_get(v);
      wr(4, 32'h20);
      wr(0, 32'h04);
      sync_get(v);
      chk("R7 carry into high word", tm(0), v + 64'd1 + 64'h20);
      chk("R7 high word", {32'd0, tm(0)[63:32]}, 64'd1);
   endtask

   task automatic t_invalid;
      logic [63:0] v;
      logic [31:0] d;
      wr(0, 32'h0C);
      sync_get(v);
      chk("R10 code 0x0C ignored", tm(0), v + 64'd1);
      rd(0, d); chk("R10 code cleared", 64'(d), 64'd0);
   endtask

   task automatic t_capture;
      logic [63:0] v;
      logic [31:0] d;
      wr(2, 32'h12345678);
      wr(3, 32'h00000007);
      wr(0, 32'h01);
      sync_get(v);
      wr(0, 32'h80);
      sync_get(v);
      for (int t = 0; t < NUM_T; t++) begin
         rd(8 + 2*t, d); chk("R8 capture low", 64'(d), {32'd0, v[31:0]});
         rd(9 + 2*t, d); chk("R8 capture high", 64'(d), {32'd0, v[63:32]});
      end
      repeat (4) @(negedge clk);
      rd(8, d); chk("R8 capture held", 64'(d), {32'd0, v[31:0]});
   endtask

   task automatic t_fraction;
      logic [63:0] v;
      wr(5, 32'h0);
      wr(4, 32'h80000000);
      wr(0, 32'h02);
      sync_get(v);
      wr(4, 32'd3);
      wr(2, 32'd0);
      wr(3, 32'd0);
      wr(0, 32'h01);
      sync_get(v);
      chk("R5 load at half rate", tm(0), 64'd0);
      wr(0, 32'h04);
      @(negedge clk);
      sync_get(v);
      chk("R2 fraction carry", v, 64'd2);
      chk("R7 adjust at half rate", tm(0), 64'd5);
      @(negedge clk);
      chk("R7 fraction kept", tm(0), 64'd6);
   endtask

   task automatic t_own;
      logic [31:0] d;
      rd(6, d); chk("R1 R11 flag free", 64'(d), 64'd0);
      rd(6, d); chk("R11 flag taken", 64'(d), 64'd1);
      rd(6, d); chk("R11 flag stays", 64'(d), 64'd1);
      wr(6, 32'd0);
      rd(6, d); chk("R11 flag released", 64'(d), 64'd0);
   endtask

   task automatic finish_run;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      t_reset();
      t_inc_and_init();
      t_stage();
      t_adjust();
      t_invalid();
      t_capture();
      t_fraction();
      t_own();
      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
   end

endmodule